// File: doc/BRIEF.md
# Multi-Mode Funnel Shifter

A purely combinational shifter for a 32-bit datapath that performs logical right, arithmetic right, rotate right and logical left shifts with a single right-going extraction network. For every mode, a selection stage picks an upper word, a lower word and an effective shift amount. The extraction network then shifts the double-width word made of those two words right by that amount and keeps the low 32 bits.

The extraction network is a chain of 2:1 multiplexer levels. Each level is steered by one bit of the effective amount. Each level also drops the bits that no later level can reach, so the last level emits exactly one word. A left shift by zero needs an effective amount equal to the full word width. That case bypasses the chain and returns the upper word directly. The block has no clock and no state: the result follows the inputs.

Top module: `funnel_shifter`

## Requirements
- R1: With mode 2'b00 (logical right), the result is the operand shifted right by the amount, with zeros filling the vacated upper bits.
- R2: With mode 2'b01 (arithmetic right), the result is the operand shifted right by the amount, with copies of operand bit 31 filling the vacated upper bits.
- R3: With mode 2'b10 (rotate right), bits shifted out at bit 0 re-enter at bit 31, so result bit k equals operand bit (k + amount) mod 32.
- R4: With mode 2'b11 (logical left), the result is the operand shifted left by the amount, with zeros filling the vacated lower bits.
- R5: A logical left shift by an amount of 0 returns the operand unchanged.
- R6: In each of the three right-going modes, an amount of 0 returns the operand unchanged.
- R7: At the largest amount, 31, logical right leaves operand bit 31 alone in bit 0, arithmetic right gives 32 copies of bit 31, rotate right moves bit 0 to bit 1 and bit 31 to bit 0, and logical left leaves operand bit 0 alone in bit 31.
- R8: The result depends only on the present inputs and settles within the same time step as an input change, with no clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd_i | input | 32 | Operand to be shifted |
| amt_i | input | 5 | Shift distance, 0 to 31 |
| mode_i | input | 2 | 00 logical right, 01 arithmetic right, 10 rotate right, 11 logical left |
| res_o | output | 32 | Shifted result |

## Verification
The bench targets the left shift by zero. A design that passed its full-width effective amount through the mux chain would return zero here instead of the operand. It checks arithmetic shifts of negative and positive operands. A sign fill taken from the wrong bit, or a fill that is always zero, shows up as wrong upper bits. The amount 31 is checked in all four modes, because an off-by-one in the left-shift amount or a missing top bit in the double word only appears at that edge. Rotates use asymmetric patterns, so a rotate in the wrong direction or one that loses the wrapped bits gives a visibly different word.

// File: rtl/funnel_pkg.sv
package funnel_pkg;

    typedef enum logic [1:0] {
        SH_LRIGHT = 2'b00,
        SH_ARIGHT = 2'b01,
        SH_ROTR   = 2'b10,
        SH_LLEFT  = 2'b11
    } shift_mode_e;

endpackage

// File: rtl/funnel_select.sv
module funnel_select
    import funnel_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH),
    localparam int SAW  = SHW + 1
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [SHW-1:0]   amt_i,
    input  logic [1:0]       mode_i,
    output logic [WIDTH-1:0] hi_o,
    output logic [WIDTH-1:0] lo_o,
    output logic [SAW-1:0]   sa_o
);

    shift_mode_e mode_s;

    always_comb begin
        mode_s = shift_mode_e'(mode_i);
        hi_o   = '0;
        lo_o   = opnd_i;
        sa_o   = SAW'(amt_i);
        unique case (mode_s)
            SH_LRIGHT: begin
                hi_o = '0;
            end
            SH_ARIGHT: begin
                hi_o = {WIDTH{opnd_i[WIDTH-1]}};
            end
            SH_ROTR: begin
                hi_o = opnd_i;
            end
            SH_LLEFT: begin
                hi_o = opnd_i;
                lo_o = '0;
                sa_o = SAW'(WIDTH) - SAW'(amt_i);
            end
            default: begin
                hi_o = '0;
            end
        endcase
    end

    // The effective amount reaches the full width only for a left shift by zero
    always_comb begin
        if (sa_o[SHW]) begin
            AST_FULL_ONLY_LEFT0: assert (mode_s == SH_LLEFT && amt_i == '0); // R5
        end
    end

endmodule

// File: rtl/funnel_level.sv
module funnel_level #(
    parameter int IN_W  = 33,
    parameter int STEP  = 1,
    localparam int OUT_W = IN_W - STEP
) (
    input  logic [IN_W-1:0]  din_i,
    input  logic             sel_i,
    output logic [OUT_W-1:0] dout_o
);

    always_comb begin
        if (sel_i) begin
            dout_o = din_i[STEP +: OUT_W];
        end else begin
            dout_o = din_i[0 +: OUT_W];
        end
    end

endmodule

// File: rtl/funnel_shifter.sv
module funnel_shifter
    import funnel_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SHW  = $clog2(WIDTH),
    localparam int SAW  = SHW + 1,
    localparam int DW   = 2 * WIDTH - 1
) (
    input  logic [WIDTH-1:0] opnd_i,
    input  logic [SHW-1:0]   amt_i,
    input  logic [1:0]       mode_i,
    output logic [WIDTH-1:0] res_o
);

    logic [WIDTH-1:0] hi_s;
    logic [WIDTH-1:0] lo_s;
    logic [SAW-1:0]   sa_s;
    logic [DW-1:0]    word_s;

    funnel_select #(.WIDTH(WIDTH)) sel_i (
        .opnd_i (opnd_i),
        .amt_i  (amt_i),
        .mode_i (mode_i),
        .hi_o   (hi_s),
        .lo_o   (lo_s),
        .sa_o   (sa_s)
    );

    // Top bit of the upper word is only reachable by a full-width shift,
    // which takes the bypass path below.
    assign word_s = {hi_s[WIDTH-2:0], lo_s};

    // Levels from the largest step down, each trimming what later levels cannot reach
    for (genvar b = SHW - 1; b >= 0; b--) begin : g_lvl
        localparam int IN_W  = WIDTH + (1 << (b + 1)) - 1;
        localparam int OUT_W = WIDTH + (1 << b) - 1;
        logic [IN_W-1:0]  in_s;
        logic [OUT_W-1:0] stage_s;
        if (b == SHW - 1) begin : g_first
            assign in_s = word_s;
        end else begin : g_next
            assign in_s = g_lvl[b + 1].stage_s;
        end
        funnel_level #(.IN_W(IN_W), .STEP(1 << b)) lvl_i (
            .din_i  (in_s),
            .sel_i  (sa_s[b]),
            .dout_o (stage_s)
        );
    end

    always_comb begin
        if (sa_s[SHW]) begin
            res_o = hi_s;
        end else begin
            res_o = g_lvl[0].stage_s;
        end
    end

    // Result-versus-input checks
    always_comb begin
        if (mode_i == SH_LRIGHT && amt_i != '0) begin
            AST_LRIGHT_TOP_ZERO: assert (res_o[WIDTH-1] == 1'b0); // R1
        end
        if (mode_i == SH_ARIGHT) begin
            AST_ARIGHT_SIGN_KEPT: assert (res_o[WIDTH-1] == opnd_i[WIDTH-1]); // R2
        end
        if (mode_i == SH_ROTR) begin
            AST_ROTR_BITS_KEPT: assert ($countones(res_o) == $countones(opnd_i)); // R3
        end
        if (mode_i == SH_LLEFT) begin
            AST_LLEFT_LOW_ZERO: assert ((res_o & ((WIDTH'(1) << amt_i) - WIDTH'(1))) == '0); // R4
        end
        if (mode_i == SH_LLEFT && amt_i == '0) begin
            AST_LLEFT_ZERO_PASS: assert (res_o == opnd_i); // R5
        end
        if (mode_i != SH_LLEFT && amt_i == '0) begin
            AST_RIGHT_ZERO_PASS: assert (res_o == opnd_i); // R6
        end
    end

endmodule

// File: tb/funnel_shifter_tb_top.sv
module funnel_shifter_tb_top;

    logic        clk = 1'b0;
    logic [31:0] opnd_s = '0;
    logic [4:0]  amt_s = '0;
    logic [1:0]  mode_s = '0;
    logic [31:0] res_s;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2.5 clk = ~clk;

    funnel_shifter dut_i (
        .opnd_i (opnd_s),
        .amt_i  (amt_s),
        .mode_i (mode_s),
        .res_o  (res_s)
    );

    function automatic logic [31:0] model(logic [31:0] a, logic [4:0] n, logic [1:0] m);
        logic [63:0] w;
        case (m)
            2'b00:   return a >> n;
            2'b01:   return $signed(a) >>> n;
            2'b10:   begin w = {a, a} >> n; return w[31:0]; end
            default: return a << n;
        endcase
    endfunction

    task automatic apply_check(input logic [31:0] a, input logic [4:0] n,
                               input logic [1:0] m, input logic [31:0] exp, input string req);
        @(posedge clk);
        {opnd_s, amt_s, mode_s} = {a, n, m};
        @(negedge clk);
        total++;
        if (res_s !== exp) begin
            bad++;
            $display("FAIL %s: a=%h n=%0d mode=%0d actual=%h expected=%h", req, a, n, m, res_s, exp);
        end
    endtask

    task automatic test_reset_state();
        apply_check(32'h0, 5'd0, 2'b00, 32'h0, "R6");
    endtask

    task automatic test_lright();   // R1
        apply_check(32'hF000_000F, 5'd4, 2'b00, 32'h0F00_0000, "R1");
        apply_check(32'h8765_4321, 5'd16, 2'b00, 32'h0000_8765, "R1");
        for (int n = 1; n < 32; n += 5)
            apply_check(32'hDEAD_BEEF, 5'(n), 2'b00, model(32'hDEAD_BEEF, 5'(n), 2'b00), "R1");
    endtask

    task automatic test_aright();   // R2
        apply_check(32'h8000_0000, 5'd4, 2'b01, 32'hF800_0000, "R2");
        apply_check(32'h7000_0001, 5'd4, 2'b01, 32'h0700_0000, "R2");
        for (int n = 1; n < 32; n += 3)
            apply_check(32'hA5C3_0F01, 5'(n), 2'b01, model(32'hA5C3_0F01, 5'(n), 2'b01), "R2");
    endtask

    task automatic test_rotr();     // R3
        apply_check(32'h0000_0001, 5'd1, 2'b10, 32'h8000_0000, "R3");
        apply_check(32'h1234_5678, 5'd8, 2'b10, 32'h7812_3456, "R3");
        for (int n = 1; n < 32; n += 4)
            apply_check(32'h0F1E_2D3C, 5'(n), 2'b10, model(32'h0F1E_2D3C, 5'(n), 2'b10), "R3");
    endtask

    task automatic test_lleft();    // R4
        apply_check(32'h0000_00FF, 5'd8, 2'b11, 32'h0000_FF00, "R4");
        apply_check(32'hFFFF_FFFF, 5'd1, 2'b11, 32'hFFFF_FFFE, "R4");
        for (int n = 1; n < 32; n += 3)
            apply_check(32'hC001_D00D, 5'(n), 2'b11, model(32'hC001_D00D, 5'(n), 2'b11), "R4");
    endtask

    task automatic test_zero_amount();  // R5 and R6
        apply_check(32'h89AB_CDEF, 5'd0, 2'b11, 32'h89AB_CDEF, "R5");
        apply_check(32'h8000_0001, 5'd0, 2'b11, 32'h8000_0001, "R5");
        apply_check(32'h89AB_CDEF, 5'd0, 2'b00, 32'h89AB_CDEF, "R6");
        apply_check(32'h89AB_CDEF, 5'd0, 2'b01, 32'h89AB_CDEF, "R6");
        apply_check(32'h89AB_CDEF, 5'd0, 2'b10, 32'h89AB_CDEF, "R6");
    endtask

    task automatic test_max_amount();   // R7
        apply_check(32'h8000_0000, 5'd31, 2'b00, 32'h0000_0001, "R7");
        apply_check(32'h8000_0000, 5'd31, 2'b01, 32'hFFFF_FFFF, "R7");
        apply_check(32'h7FFF_FFFF, 5'd31, 2'b01, 32'h0000_0000, "R7");
        apply_check(32'h8000_0001, 5'd31, 2'b10, 32'h0000_0003, "R7");
        apply_check(32'h0000_0001, 5'd31, 2'b11, 32'h8000_0000, "R7");
        apply_check(32'hFFFF_FFFE, 5'd31, 2'b11, 32'h0000_0000, "R7");
    endtask

    task automatic test_no_clock(); // R8
        @(negedge clk);
        {opnd_s, amt_s, mode_s} = {32'h0000_0F00, 5'd4, 2'b00};
        #0.5;
        total++;
        if (res_s !== 32'h0000_00F0) begin
            bad++;
            $display("FAIL R8: actual=%h expected=%h", res_s, 32'h0000_00F0);
        end
        {opnd_s, amt_s, mode_s} = {32'h0000_0F00, 5'd4, 2'b11};
        #0.5;
        total++;
        if (res_s !== 32'h0000_F000) begin
            bad++;
            $display("FAIL R8: actual=%h expected=%h", res_s, 32'h0000_F000);
        end
    endtask

    initial begin
        test_reset_state();
        test_lright();
        test_aright();
        test_rotr();
        test_lleft();
        test_zero_amount();
        test_max_amount();
        test_no_clock();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule